// File: doc/BRIEF.md
# Integer Divider with Condition Codes

This unit is a multi-cycle integer divider for a processor execute stage. Four operation modes are selected by a two-bit code. The two narrow forms divide a full-width dividend by a half-width divisor. They return one packed word that holds the half-width remainder in its upper half and the half-width quotient in its lower half. The two wide forms divide a double-width dividend by a full-width divisor. The dividend is assembled from a high operand, which is the remainder register's value, and a low operand, which is the quotient register's value. These forms return a full-width quotient and a full-width remainder.

The caller presents operands and a mode, and pulses `start` while the unit is idle. The unit answers with a one-cycle `done` pulse that carries register write strobes and updated N, Z, V and C flags. For a zero divisor it instead answers with a one-cycle `trap` pulse and leaves every flag alone. The core is a restoring shift-subtract loop that works on magnitudes. Signs are applied in one fix-up cycle at the end, and the overflow decision is made in the same cycle. Overflow is fully defined: nothing is written, V is set, C and Z are cleared, and N keeps its old value. The register file and the trap vectoring live outside the unit.

Top module: `divUnit`

## Requirements
- R1: `mode[1]` selects the wide forms (1) or the narrow forms (0), and `mode[0]` selects signed (1) or unsigned (0) arithmetic. A narrow result without overflow pulses `quoWe` with `quoData[W-1:W/2]` = remainder and `quoData[W/2-1:0]` = quotient. `remWe` stays low. Only `dividendLo` and `divisor[W/2-1:0]` are used.
- R2: Unsigned narrow division overflows when the quotient exceeds 2^(W/2)-1. Signed narrow division overflows when the quotient lies outside the signed W/2-bit range.
- R3: A wide form divides {`dividendHi`,`dividendLo`} by `divisor`. Without overflow it returns the quotient on `quoData` and the remainder on `remData`, pulsing `quoWe` and `remWe`. It overflows when the quotient does not fit in W bits (unsigned) or in signed W bits (signed).
- R4: Signed division truncates toward zero. A nonzero remainder carries the sign of the dividend.
- R5: On success, N is the top bit of the quotient (bit W/2-1 in the narrow forms, bit W-1 in the wide forms), Z is set exactly when that quotient is zero, and V and C are cleared. Flags change only on a `done` pulse.
- R6: On overflow, `done` pulses with `quoWe` and `remWe` low. V becomes 1, C and Z become 0, and N keeps its previous value.
- R7: A zero divisor (`divisor[W/2-1:0]` in the narrow forms, all of `divisor` in the wide forms) raises `trap` for one cycle, in the cycle after the start edge. No `done`, no write strobe and no flag change follow, and the unit stays idle.
- R8: In the wide forms with `sameDest` high at start, only the quotient is written: `remWe` stays low.
- R9: `done` rises W+2 clock edges after the start edge for narrow forms and 2W+2 for wide forms, counting the start edge as the first. `busy` is high in between.
- R10: A `start` pulse while `busy` is high is ignored. Operand, mode and `sameDest` changes made during an operation do not alter its result.
- R11: During reset, `busy`, `done`, `trap`, `quoWe`, `remWe` and all four flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | Bit 1: wide form; bit 0: signed |
| dividendHi | input | W | Upper dividend word (wide forms only) |
| dividendLo | input | W | Lower dividend word, or the whole dividend in the narrow forms |
| divisor | input | W | Divisor; the narrow forms use the low W/2 bits |
| sameDest | input | 1 | Quotient and remainder share one destination register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle divide-by-zero pulse |
| quoWe | output | 1 | Write strobe for the quotient destination |
| remWe | output | 1 | Write strobe for the remainder destination |
| quoData | output | W | Quotient, or the packed remainder and quotient |
| remData | output | W | Remainder (wide forms) |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag, always cleared on completion |

## Verification
The bench runs with W=8. It sweeps every narrow dividend against every divisor nibble in both signedness modes. In the wide forms it crosses chosen high words, low words and divisors. This covers the most negative dividend divided by minus one: a design that negates quotients without a range check would write a wrapped positive value instead of flagging overflow. It also covers negative dividends with exact and inexact quotients, where a floor-rounding design would return the wrong quotient and a remainder of the wrong sign. A sequence with an overflow after a negative result checks that N is retained rather than recomputed from a discarded quotient. Divisors with a zero low nibble but nonzero upper bits catch a zero test that looks at the wrong width. Start pulses with altered operands in the middle of a division catch a design that re-latches its inputs while busy.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes the sequencer hands to the datapath.
  typedef struct packed {
    logic load;    // capture operand magnitudes and signs
    logic step;    // one restoring shift-subtract iteration
    logic finish;  // sign fix-up, range check, result and flag update
  } divCtlT;

  localparam int MODE_WIDE_BIT   = 1;
  localparam int MODE_SIGNED_BIT = 0;

endpackage

// File: rtl/divCtl.sv
module divCtl
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   isWide,
  input  logic   divIsZero,
  output divCtlT ctl,
  output logic   busy,
  output logic   done,
  output logic   trap
);

  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] WIDE_LAST   = CW'(2 * W - 1);
  localparam logic [CW-1:0] NARROW_LAST = CW'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} stateT;

  stateT         state;
  logic [CW-1:0] iterLeft;
  logic          accept;

  assign accept     = start && (state == ST_IDLE);
  assign ctl.load   = accept && !divIsZero;
  assign ctl.step   = (state == ST_RUN);
  assign ctl.finish = (state == ST_FIX);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
      trap     <= 1'b0;
    end else begin
      done <= ctl.finish;
      trap <= accept && divIsZero;
      unique case (state)
        ST_IDLE: begin
          if (ctl.load) begin
            state    <= ST_RUN;
            iterLeft <= isWide ? WIDE_LAST : NARROW_LAST;
          end
        end
        ST_RUN: begin
          if (iterLeft == '0) state <= ST_FIX;
          else                iterLeft <= iterLeft - 1'b1;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  divCtlT       ctl,
  input  logic [1:0]   mode,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  input  logic         sameDest,
  output logic         divIsZero,
  output logic         quoWe,
  output logic         remWe,
  output logic [W-1:0] quoData,
  output logic [W-1:0] remData,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);

  localparam int H  = W / 2;
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] ONE_D        = DW'(1);
  localparam logic [DW-1:0] NARROW_S_LIM = ONE_D << (H - 1);
  localparam logic [DW-1:0] WIDE_S_LIM   = ONE_D << (W - 1);

  // ---- operand decode (combinational, used at load) ----
  logic          wideIn, signedIn;
  logic          narrowDvdNeg, wideDvdNeg, dvdNeg;
  logic [W-1:0]  narrowDvdMag;
  logic [DW-1:0] wideDvd, wideDvdMag, loadQuo;
  logic [H-1:0]  narrowDiv, narrowDivMag;
  logic          narrowDivNeg, wideDivNeg, divNeg;
  logic [W-1:0]  wideDivMag, loadDiv;

  assign wideIn    = mode[MODE_WIDE_BIT];
  assign signedIn  = mode[MODE_SIGNED_BIT];
  assign narrowDiv = divisor[H-1:0];
  assign divIsZero = wideIn ? (divisor == '0) : (narrowDiv == '0);

  always_comb begin
    wideDvd      = {dividendHi, dividendLo};
    narrowDvdNeg = signedIn && dividendLo[W-1];
    wideDvdNeg   = signedIn && dividendHi[W-1];
    narrowDvdMag = narrowDvdNeg ? -dividendLo : dividendLo;
    wideDvdMag   = wideDvdNeg ? -wideDvd : wideDvd;
    dvdNeg       = wideIn ? wideDvdNeg : narrowDvdNeg;
    // The narrow dividend sits in the upper half so that W steps finish it.
    loadQuo      = wideIn ? wideDvdMag : {narrowDvdMag, {W{1'b0}}};

    narrowDivNeg = signedIn && narrowDiv[H-1];
    wideDivNeg   = signedIn && divisor[W-1];
    narrowDivMag = narrowDivNeg ? -narrowDiv : narrowDiv;
    wideDivMag   = wideDivNeg ? -divisor : divisor;
    divNeg       = wideIn ? wideDivNeg : narrowDivNeg;
    loadDiv      = wideIn ? wideDivMag : {{H{1'b0}}, narrowDivMag};
  end

  // ---- iteration state ----
  logic [1:0]    modeR;
  logic          sameR;
  logic [DW-1:0] quoSh;
  logic [W-1:0]  remR;
  logic [W-1:0]  divMag;
  logic          negQ, negR;

  logic [W:0]    shifted;
  logic          fits;
  logic [W-1:0]  diff;

  always_comb begin
    shifted = {remR, quoSh[DW-1]};
    fits    = shifted >= {1'b0, divMag};
    // The true difference is below divMag, so the low W bits are exact.
    diff    = shifted[W-1:0] - divMag;
  end

  // ---- fix-up (combinational, used at finish) ----
  logic          wideR, signedR;
  logic [DW-1:0] sLim;
  logic          signedOvf, unsignedOvf, ovf;
  logic [W-1:0]  qLow, qVal, rVal;
  logic          qTop, qZero;

  always_comb begin
    wideR       = modeR[MODE_WIDE_BIT];
    signedR     = modeR[MODE_SIGNED_BIT];
    sLim        = wideR ? WIDE_S_LIM : NARROW_S_LIM;
    signedOvf   = negQ ? (quoSh > sLim) : (quoSh >= sLim);
    unsignedOvf = wideR ? (|quoSh[DW-1:W]) : (|quoSh[DW-1:H]);
    ovf         = signedR ? signedOvf : unsignedOvf;
    qLow        = quoSh[W-1:0];
    qVal        = negQ ? -qLow : qLow;
    rVal        = negR ? -remR : remR;
    qTop        = wideR ? qVal[W-1] : qVal[H-1];
    qZero       = wideR ? (qVal == '0) : (qVal[H-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR   <= '0;
      sameR   <= 1'b0;
      quoSh   <= '0;
      remR    <= '0;
      divMag  <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      quoWe   <= 1'b0;
      remWe   <= 1'b0;
      quoData <= '0;
      remData <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagV   <= 1'b0;
      flagC   <= 1'b0;
    end else begin
      quoWe <= 1'b0;
      remWe <= 1'b0;
      if (ctl.load) begin
        modeR  <= mode;
        sameR  <= sameDest;
        quoSh  <= loadQuo;
        remR   <= '0;
        divMag <= loadDiv;
        negQ   <= dvdNeg ^ divNeg;
        negR   <= dvdNeg;
      end
      if (ctl.step) begin
        quoSh <= {quoSh[DW-2:0], fits};
        remR  <= fits ? diff : shifted[W-1:0];
      end
      if (ctl.finish) begin
        flagC <= 1'b0;
        if (ovf) begin
          flagV <= 1'b1;
          flagZ <= 1'b0;
        end else begin
          quoWe   <= 1'b1;
          remWe   <= wideR && !sameR;
          quoData <= wideR ? qVal : {rVal[H-1:0], qVal[H-1:0]};
          remData <= rVal;
          flagN   <= qTop;
          flagZ   <= qZero;
          flagV   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/divUnit.sv
module divUnit
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  input  logic         sameDest,
  output logic         busy,
  output logic         done,
  output logic         trap,
  output logic         quoWe,
  output logic         remWe,
  output logic [W-1:0] quoData,
  output logic [W-1:0] remData,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);

  divCtlT ctl;
  logic   divIsZero;

  divCtl #(.W(W)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .isWide    (mode[MODE_WIDE_BIT]),
    .divIsZero (divIsZero),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .trap      (trap)
  );

  divDatapath #(.W(W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .mode       (mode),
    .dividendHi (dividendHi),
    .dividendLo (dividendLo),
    .divisor    (divisor),
    .sameDest   (sameDest),
    .divIsZero  (divIsZero),
    .quoWe      (quoWe),
    .remWe      (remWe),
    .quoData    (quoData),
    .remData    (remData),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .flagV      (flagV),
    .flagC      (flagC)
  );

endmodule

// File: rtl/divUnitChk.sv
module divUnitChk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic trap,
  input logic quoWe,
  input logic remWe,
  input logic flagN,
  input logic flagZ,
  input logic flagV,
  input logic flagC
);

  assert_done_trap_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && trap));

  assert_trap_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> (!quoWe && !remWe && $stable({flagN, flagZ, flagV, flagC})));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({flagN, flagZ, flagV, flagC}));

  assert_overflow_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && flagV) |-> (!quoWe && !remWe && !flagZ && !flagC && $stable(flagN)));

  assert_success_writes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !flagV) |-> quoWe);

  assert_strobe_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (quoWe || remWe) |-> done);

  assert_rem_needs_quo_R8: assert property (@(posedge clk) disable iff (!rstN)
    remWe |-> quoWe);

  assert_busy_ends_in_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind divUnit divUnitChk uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .trap  (trap),
  .quoWe (quoWe),
  .remWe (remWe),
  .flagN (flagN),
  .flagZ (flagZ),
  .flagV (flagV),
  .flagC (flagC)
);

// File: tb/sim_divUnit.sv
`timescale 1ns/1ps
module sim_divUnit;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] dividendHi = '0;
  logic [W-1:0] dividendLo = '0;
  logic [W-1:0] divisor = '0;
  logic         sameDest = 1'b0;
  logic         busy, done, trap, quoWe, remWe;
  logic [W-1:0] quoData, remData;
  logic         flagN, flagZ, flagV, flagC;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;
  bit mN = 1'b0, mZ = 1'b0, mV = 1'b0, mC = 1'b0;

  always #2.5 clk = ~clk;

  divUnit #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .sameDest(sameDest), .busy(busy), .done(done), .trap(trap),
    .quoWe(quoWe), .remWe(remWe), .quoData(quoData), .remData(remData),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] flagVec();
    return {flagN, flagZ, flagV, flagC};
  endfunction

  task automatic runOp(input logic [1:0] m, input logic [7:0] hi,
                       input logic [7:0] lo, input logic [7:0] dv,
                       input logic same, input bit disturb);
    longint a, b, q, r;
    bit wide, sgn, zero, ovf, expRemWe;
    logic [7:0] expQ, expR;
    int cyc, lat;
    string tag;
    wide = m[1];
    sgn  = m[0];
    zero = wide ? (dv == 8'h00) : (dv[3:0] == 4'h0);
    if (wide) begin
      a = sgn ? longint'($signed({hi, lo})) : longint'({hi, lo});
      b = sgn ? longint'($signed(dv)) : longint'(dv);
    end else begin
      a = sgn ? longint'($signed(lo)) : longint'(lo);
      b = sgn ? longint'($signed(dv[3:0])) : longint'(dv[3:0]);
    end
    q = 0;
    r = 0;
    if (!zero) begin
      q = a / b;
      r = a % b;
    end
    if (wide) ovf = sgn ? (q > 127 || q < -128) : (q > 255);
    else      ovf = sgn ? (q > 7 || q < -8) : (q > 15);

    @(negedge clk);
    mode = m; dividendHi = hi; dividendLo = lo; divisor = dv; sameDest = same;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 1;

    if (zero) begin
      // R7: trap now, nothing written, flags untouched
      chk(trap === 1'b1 && done === 1'b0 && quoWe === 1'b0 && remWe === 1'b0
          && busy === 1'b0 && flagVec() === {mN, mZ, mV, mC},
          "R7", "zero divisor", {trap, done, quoWe, remWe, flagVec()},
          {1'b1, 3'b000, mN, mZ, mV, mC});
      return;
    end

    while (done !== 1'b1 && cyc < 300) begin
      if (disturb && cyc == 3) begin
        // R10: a start during busy with different operands
        start = 1'b1; mode = ~m; dividendLo = ~lo; dividendHi = ~hi;
        divisor = 8'h01; sameDest = ~same;
      end else if (disturb && cyc == 4) begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      cyc++;
    end
    lat = wide ? 2 * W + 2 : W + 2;
    chk(cyc == lat, "R9", "done latency", cyc, lat);

    if (wide) tag = sgn ? "R3 R4" : "R3";
    else      tag = sgn ? "R1 R4" : "R1";
    if (disturb) tag = "R10";
    else if (wide && same) tag = "R8";

    if (ovf) begin
      mV = 1'b1; mZ = 1'b0; mC = 1'b0;
      chk(quoWe === 1'b0 && remWe === 1'b0, wide ? "R3 R6" : "R2 R6",
          "overflow write strobes", {quoWe, remWe}, 0);
      chk(flagVec() === {mN, mZ, mV, mC}, "R6", "overflow flags",
          flagVec(), {mN, mZ, mV, mC});
    end else begin
      expQ = wide ? q[7:0] : {r[3:0], q[3:0]};
      expR = r[7:0];
      expRemWe = wide && !same;
      chk(quoWe === 1'b1 && remWe === expRemWe && quoData === expQ &&
          (!expRemWe || remData === expR), tag, "result",
          {quoWe, remWe, quoData, remData}, {1'b1, expRemWe, expQ, expR});
      mN = wide ? q[7] : q[3];
      mZ = wide ? (q[7:0] == 0) : (q[3:0] == 0);
      mV = 1'b0;
      mC = 1'b0;
      chk(flagVec() === {mN, mZ, mV, mC}, "R5", "flags",
          flagVec(), {mN, mZ, mV, mC});
    end
  endtask

  logic [7:0] hiSet [8] = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hff, 8'h3c, 8'hc3, 8'h05};
  logic [7:0] loSet [6] = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hff, 8'h35};
  logic [7:0] dvSet [9] = '{8'h01, 8'h02, 8'h03, 8'h7f, 8'h80, 8'hff, 8'h00, 8'h10, 8'h81};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk({busy, done, trap, quoWe, remWe, flagVec()} === 9'h000, "R11",
        "reset outputs", {busy, done, trap, quoWe, remWe, flagVec()}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // Narrow forms: every dividend against every divisor nibble.
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) begin
        for (int d = 0; d < 16; d++) begin
          runOp(m[1:0], i[7:0] ^ 8'h3c, i[7:0], {d[3:0] ^ 4'h5, d[3:0]}, 1'b0, 1'b0);
        end
      end
    end

    // Wide forms: cross product of chosen words.
    for (int m = 2; m < 4; m++) begin
      for (int h = 0; h < 8; h++) begin
        for (int l = 0; l < 6; l++) begin
          for (int d = 0; d < 9; d++) begin
            runOp(m[1:0], hiSet[h], loSet[l], dvSet[d], ((h + l + d) % 2) == 1, 1'b0);
          end
        end
      end
    end

    // R6: negative result, then overflow keeps N set
    runOp(2'b01, 8'h00, 8'hf9, 8'h01, 1'b0, 1'b0);
    runOp(2'b01, 8'h00, 8'h80, 8'h0f, 1'b0, 1'b0);
    runOp(2'b11, 8'hff, 8'hf0, 8'h03, 1'b0, 1'b0);
    runOp(2'b11, 8'h80, 8'h00, 8'hff, 1'b0, 1'b0);

    // R10: start pulses mid-operation are ignored
    runOp(2'b00, 8'h00, 8'hc8, 8'h07, 1'b0, 1'b1);
    runOp(2'b01, 8'h00, 8'h9d, 8'h03, 1'b0, 1'b1);
    runOp(2'b10, 8'h12, 8'h34, 8'h56, 1'b0, 1'b1);
    runOp(2'b11, 8'hf0, 8'h01, 8'h07, 1'b1, 1'b1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule